// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a parameterized set of level-sensitive interrupt request lines, between 2 and 32 of them. Each line can also be raised by a software trigger. Among the lines that are both requesting and unmasked, the block picks the one with the lowest index. It copies that line's entry from an internal vector table into a vector address register and asserts a single interrupt output. The polarity of that output is programmable.

Once a line has been latched for service, the selection stays frozen until software writes the end-of-interrupt port. After that write the controller goes back to arbitration and takes the next pending line on the following clock.

Software reaches everything through a flat word-addressed register port with a single address. Writes take effect on the clock edge. Reads are combinational from the current address.

The port addresses are as follows:

| Address | Function |
|---|---|
| 0x00 | Control: bit 0 is the global enable, bit 1 the polarity |
| 0x01 | Raw line levels |
| 0x02 | Write-1 enable |
| 0x03 | Write-1 disable |
| 0x04 | Mask readback |
| 0x05 | Latched vector address |
| 0x06 | Write-1 software trigger |
| 0x07 | End-of-interrupt |
| 0x20 + n | Vector table word n |

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the control register reads 0 (controller off, polarity 0). The mask reads 0, the vector address reads 0 and `irq_o` sits at its inactive level, which is 1 when the polarity is 0.
- R2: Reading address 0x01 returns the live level of every `irq_i` line in bits [NUM_IRQ-1:0], whatever the mask holds.
- R3: A write to 0x02 sets the mask bit of every line whose data bit is 1. A write to 0x03 clears the mask bit of every such line. Data bits of 0 leave the mask unchanged. Address 0x04 reads the mask back, with 1 for each enabled line.
- R4: A line is pending when its input is high or its software trigger is set, and its mask bit is 1. When several lines are pending, the lowest index is taken.
- R5: Vector table word n (address 0x20+n) is writable and readable for n < NUM_IRQ and reads 0 otherwise. Taking interrupt n copies word n into the vector address register (address 0x05) on the same edge.
- R6: While an interrupt is in service and the controller is on, `irq_o` equals the polarity bit. Otherwise `irq_o` is its inverse.
- R7: While in service, the vector address and `irq_o` stay unchanged even when a higher-priority line becomes pending.
- R8: Any write to 0x07 ends service on that edge. If another line is pending, it is taken on the next edge.
- R9: Writing 1 to bit n of 0x06 makes line n pending. It stays pending until an end-of-interrupt acknowledges line n.
- R10: While the control enable bit is 0, `irq_o` is inactive and nothing is latched. Clearing enable during service drops the service.
- R11: A requesting line whose mask bit is 0 is never taken and does not affect `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_IRQ | Level interrupt requests, active high |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register word address for reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt output, level set by the polarity bit |

## Verification
The embedded assertions watch several properties on every cycle. They check the write-1 set and clear effect on the mask, and that the chosen index is pending with nothing pending below it. They also check that a pending line is latched from idle, that the vector address stays frozen throughout service, that end-of-interrupt releases service, and that service is never active while the controller is off. Other behaviour only shows through the bench's scenarios. This covers the vector contents that reach the address register, the priority outcome across every request pattern of an 8-line configuration, software triggers persisting across another line's service, masked lines staying silent, and the output level under both polarities.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
   localparam int ADDR_W = 6;
   localparam int DATA_W = 32;
   localparam int IDX_W  = 5;
   localparam int MAX_IRQ = 32;

   localparam logic [ADDR_W-1:0] ADR_CTRL  = 6'h00;
   localparam logic [ADDR_W-1:0] ADR_RAW   = 6'h01;
   localparam logic [ADDR_W-1:0] ADR_ENSET = 6'h02;
   localparam logic [ADDR_W-1:0] ADR_ENCLR = 6'h03;
   localparam logic [ADDR_W-1:0] ADR_MASK  = 6'h04;
   localparam logic [ADDR_W-1:0] ADR_VEC   = 6'h05;
   localparam logic [ADDR_W-1:0] ADR_SOFT  = 6'h06;
   localparam logic [ADDR_W-1:0] ADR_EOI   = 6'h07;
   localparam int TBL_SEL_BIT = 5;

   typedef enum logic {
      SVC_IDLE = 1'b0,
      SVC_BUSY = 1'b1
   } svc_state_e;
endpackage

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc #(
   parameter int NUM_IRQ = 32
) (
   input  logic [NUM_IRQ-1:0]       req_i,
   output logic                     vld_o,
   output logic [ivc_pkg::IDX_W-1:0] idx_o
);
   always_comb begin
      vld_o = 1'b0;
      idx_o = '0;
      for (int i = NUM_IRQ - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            vld_o = 1'b1;
            idx_o = ivc_pkg::IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/ivc_vec_table.sv
module ivc_vec_table #(
   parameter int NUM_IRQ = 32,
   parameter int DW      = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en_i,
   input  logic [ivc_pkg::IDX_W-1:0] wr_idx_i,
   input  logic [DW-1:0]             wr_data_i,
   input  logic [ivc_pkg::IDX_W-1:0] bus_idx_i,
   output logic [DW-1:0]             bus_data_o,
   input  logic [ivc_pkg::IDX_W-1:0] svc_idx_i,
   output logic [DW-1:0]             svc_data_o
);
   localparam int TW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
   localparam logic [ivc_pkg::IDX_W-1:0] LAST = ivc_pkg::IDX_W'(NUM_IRQ - 1);

   logic [DW-1:0] mem [NUM_IRQ];

   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[g] <= '0;
         else if (wr_en_i && wr_idx_i == ivc_pkg::IDX_W'(g))
            mem[g] <= wr_data_i;
      end
   end

   assign bus_data_o = (bus_idx_i <= LAST) ? mem[bus_idx_i[TW-1:0]] : '0;
   assign svc_data_o = (svc_idx_i <= LAST) ? mem[svc_idx_i[TW-1:0]] : '0;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import ivc_pkg::*;
#(
   parameter int NUM_IRQ = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_i,
   input  logic               reg_wr_i,
   input  logic [ADDR_W-1:0]  reg_addr_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   output logic [DATA_W-1:0]  reg_rdata_o,
   output logic               irq_o
);
   if (NUM_IRQ < 2 || NUM_IRQ > MAX_IRQ) begin : g_bad_cfg
      $error("irq_vector_ctrl: NUM_IRQ must lie in 2..32");
   end

   logic               ctrl_en, ctrl_pol;
   logic [NUM_IRQ-1:0] mask_q, soft_q;
   svc_state_e         state_q;
   logic [IDX_W-1:0]   cur_idx;
   logic [DATA_W-1:0]  vec_q;

   logic [NUM_IRQ-1:0] wbits, pending, ack_bits;
   logic               wr_ctrl, wr_set, wr_clr, wr_soft, wr_eoi, wr_tbl;
   logic               grant_vld;
   logic [IDX_W-1:0]   grant_idx;
   logic [DATA_W-1:0]  tbl_bus, tbl_svc;
   logic               in_service;

   assign wbits   = reg_wdata_i[NUM_IRQ-1:0];
   assign wr_ctrl = reg_wr_i && reg_addr_i == ADR_CTRL;
   assign wr_set  = reg_wr_i && reg_addr_i == ADR_ENSET;
   assign wr_clr  = reg_wr_i && reg_addr_i == ADR_ENCLR;
   assign wr_soft = reg_wr_i && reg_addr_i == ADR_SOFT;
   assign wr_eoi  = reg_wr_i && reg_addr_i == ADR_EOI;
   assign wr_tbl  = reg_wr_i && reg_addr_i[TBL_SEL_BIT];

   assign pending    = (irq_i | soft_q) & mask_q;
   assign in_service = (state_q == SVC_BUSY);

   ivc_prio_enc #(.NUM_IRQ(NUM_IRQ)) u_prio (
      .req_i (pending),
      .vld_o (grant_vld),
      .idx_o (grant_idx)
   );

   ivc_vec_table #(.NUM_IRQ(NUM_IRQ), .DW(DATA_W)) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (wr_tbl),
      .wr_idx_i   (reg_addr_i[IDX_W-1:0]),
      .wr_data_i  (reg_wdata_i),
      .bus_idx_i  (reg_addr_i[IDX_W-1:0]),
      .bus_data_o (tbl_bus),
      .svc_idx_i  (grant_idx),
      .svc_data_o (tbl_svc)
   );

   // Control and mask registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en  <= 1'b0;
         ctrl_pol <= 1'b0;
         mask_q   <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_en  <= reg_wdata_i[0];
            ctrl_pol <= reg_wdata_i[1];
         end
         if (wr_set)
            mask_q <= mask_q | wbits;
         else if (wr_clr)
            mask_q <= mask_q & ~wbits;
      end
   end

   // Acknowledge vector for the line in service
   always_comb begin
      ack_bits = '0;
      for (int i = 0; i < NUM_IRQ; i++)
         if (wr_eoi && in_service && cur_idx == IDX_W'(i))
            ack_bits[i] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         soft_q <= '0;
      else
         soft_q <= (soft_q | (wr_soft ? wbits : '0)) & ~ack_bits;
   end

   // Service state machine
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SVC_IDLE;
         cur_idx <= '0;
         vec_q   <= '0;
      end else if (!ctrl_en) begin
         state_q <= SVC_IDLE;
      end else begin
         case (state_q)
            SVC_IDLE: if (grant_vld) begin
               state_q <= SVC_BUSY;
               cur_idx <= grant_idx;
               vec_q   <= tbl_svc;
            end
            SVC_BUSY: if (wr_eoi) state_q <= SVC_IDLE;
            default:  state_q <= SVC_IDLE;
         endcase
      end
   end

   assign irq_o = (in_service && ctrl_en) ? ctrl_pol : ~ctrl_pol;

   // Read mux
   always_comb begin
      reg_rdata_o = '0;
      if (reg_addr_i[TBL_SEL_BIT]) begin
         reg_rdata_o = tbl_bus;
      end else begin
         case (reg_addr_i)
            ADR_CTRL: reg_rdata_o[1:0]         = {ctrl_pol, ctrl_en};
            ADR_RAW:  reg_rdata_o[NUM_IRQ-1:0] = irq_i;
            ADR_MASK: reg_rdata_o[NUM_IRQ-1:0] = mask_q;
            ADR_VEC:  reg_rdata_o              = vec_q;
            default:  reg_rdata_o              = '0;
         endcase
      end
   end

   // Assertions
   p_mask_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((mask_q & $past(wbits)) == $past(wbits)));
   p_mask_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((mask_q & $past(wbits)) == '0));
   p_grant_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vld |-> (pending[grant_idx] &&
                    ((pending & ((NUM_IRQ'(1) << grant_idx) - NUM_IRQ'(1))) == '0)));
   p_take_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_service && ctrl_en && (|pending)) |=> in_service);
   p_vec_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_service && !wr_eoi) |=> $stable(vec_q));
   p_eoi_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_service && wr_eoi) |=> !in_service);
   p_off_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en |=> !in_service);
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] irq_i = '0;
   logic        reg_wr_i = 1'b0;
   logic [5:0]  reg_addr_i = '0;
   logic [31:0] reg_wdata_i = '0;
   logic [31:0] reg_rdata_o;
   logic        irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_vector_ctrl #(.NUM_IRQ(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .reg_wr_i(reg_wr_i),
      .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
      .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
   );

   function automatic logic [31:0] tv(int i);
      return 32'hA000_0000 | (32'(i) * 32'h0000_0111);
   endfunction

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(logic [5:0] a, logic [31:0] d);
      reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
      step(1);
      reg_wr_i = 1'b0;
   endtask

   task automatic rd(logic [5:0] a, output logic [31:0] d);
      reg_addr_i = a;
      #1;
      d = reg_rdata_o;
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk_rd(string tag, logic [5:0] a, logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(tag, d, exp);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      step(2);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      chk("R1 irq_o", 32'(irq_o), 32'd1);
      chk_rd("R1 ctrl", 6'h00, 32'h0);
      chk_rd("R1 mask", 6'h04, 32'h0);
      chk_rd("R1 vec", 6'h05, 32'h0);

      // R5 vector table
      for (int i = 0; i < N; i++) wr(6'h20 + 6'(i), tv(i));
      wr(6'h29, 32'hDEAD_BEEF);
      for (int i = 0; i < N; i++) chk_rd("R5 table", 6'h20 + 6'(i), tv(i));
      chk_rd("R5 table out of range", 6'h29, 32'h0);

      // R2 raw status, unaffected by empty mask
      for (int p = 0; p < 256; p += 37) begin
         irq_i = 8'(p);
         chk_rd("R2 raw", 6'h01, 32'(p));
      end
      irq_i = '0;

      // R3 mask set/clear
      wr(6'h02, 32'hA5); chk_rd("R3 set", 6'h04, 32'hA5);
      wr(6'h02, 32'h00); chk_rd("R3 set zero", 6'h04, 32'hA5);
      wr(6'h03, 32'h81); chk_rd("R3 clear", 6'h04, 32'h24);
      wr(6'h03, 32'h00); chk_rd("R3 clear zero", 6'h04, 32'h24);
      wr(6'h02, 32'hFF); chk_rd("R3 set all", 6'h04, 32'hFF);

      // R10 disabled: nothing latched
      irq_i = 8'h04;
      step(3);
      chk("R10 off irq_o", 32'(irq_o), 32'd1);
      chk_rd("R10 off vec", 6'h05, 32'h0);
      irq_i = '0;

      // Enable, polarity active high
      wr(6'h00, 32'h3);
      chk("R6 idle level", 32'(irq_o), 32'd0);

      // R4/R5/R6/R8 single lines
      for (int i = 0; i < N; i++) begin
         irq_i = 8'(1 << i);
         step(1);
         chk("R6 active", 32'(irq_o), 32'd1);
         chk_rd("R5 vec single", 6'h05, tv(i));
         irq_i = '0;
         wr(6'h07, 32'h0);
         chk("R8 eoi release", 32'(irq_o), 32'd0);
      end

      // R4 priority sweep over every pattern
      for (int p = 1; p < 256; p++) begin
         int lo;
         lo = 0;
         while (((p >> lo) & 1) == 0) lo++;
         irq_i = 8'(p);
         step(1);
         chk_rd("R4 priority", 6'h05, tv(lo));
         irq_i = '0;
         wr(6'h07, 32'h0);
      end

      // R7 hold, R8 next pending taken next edge
      irq_i = 8'h80;
      step(1);
      irq_i = 8'h81;
      step(3);
      chk_rd("R7 vec frozen", 6'h05, tv(7));
      chk("R7 irq_o held", 32'(irq_o), 32'd1);
      wr(6'h07, 32'h0);
      chk("R8 idle after eoi", 32'(irq_o), 32'd0);
      step(1);
      chk_rd("R8 next taken", 6'h05, tv(0));
      irq_i = '0;
      wr(6'h07, 32'h0);

      // R11 masked line ignored
      wr(6'h03, 32'h08);
      irq_i = 8'h08;
      step(3);
      chk("R11 masked irq_o", 32'(irq_o), 32'd0);
      chk_rd("R11 masked vec", 6'h05, tv(0));
      irq_i = '0;
      wr(6'h02, 32'h08);

      // R9 software trigger
      wr(6'h06, 32'h20);
      step(1);
      chk_rd("R9 soft vec", 6'h05, tv(5));
      chk("R9 soft irq_o", 32'(irq_o), 32'd1);
      wr(6'h07, 32'h0);
      step(3);
      chk("R9 soft cleared by eoi", 32'(irq_o), 32'd0);
      irq_i = 8'h04;
      step(1);
      wr(6'h06, 32'h40);
      irq_i = '0;
      step(2);
      chk_rd("R9 serving hw line", 6'h05, tv(2));
      wr(6'h07, 32'h0);
      step(1);
      chk_rd("R9 soft kept pending", 6'h05, tv(6));
      wr(6'h07, 32'h0);
      chk("R9 soft done", 32'(irq_o), 32'd0);

      // R6 active-low polarity, R10 disable in service
      wr(6'h00, 32'h1);
      chk("R6 low idle level", 32'(irq_o), 32'd1);
      irq_i = 8'h02;
      step(1);
      chk("R6 active low", 32'(irq_o), 32'd0);
      wr(6'h00, 32'h0);
      chk("R10 disable drops", 32'(irq_o), 32'd1);
      step(3);
      chk("R10 stays off", 32'(irq_o), 32'd1);
      wr(6'h00, 32'h1);
      step(1);
      chk("R10 re-enable takes", 32'(irq_o), 32'd0);
      irq_i = '0;
      wr(6'h07, 32'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule